// File: doc/BRIEF.md
# Camera Video Output Formatter

This block sits at the end of a camera's pixel pipeline and turns already-processed pixel values into the 8-bit byte stream of a parallel video port, one byte per pixel clock. Upstream logic presents luma/chroma values, 5-6-5 colour components or a 10-bit raw sensor sample, together with a line-valid strobe. The block picks bytes out of those inputs in the order that the active format and byte-order mode call for. Holding the inputs stable across a pixel group is up to the upstream logic. The block does no colour conversion. It only serialises the values and orders the bytes.

Four format families are supported. Two are luma/chroma: one with embedded timing codes and one without. The other two are packed 5-6-5 colour and raw sensor data. Format and mode come from software-held inputs and are taken only at a frame boundary. In the embedded-code family, each active line is wrapped in a four-byte start code before it and a four-byte end code after it, and idle cycles carry alternating chroma/luma blanking levels. Every path has the same four-cycle latency, which leaves room for the start code ahead of the first pixel byte.

Top module: `pixbyte_fmt`

## Requirements
- R1: During reset and after it, data_o is 0x00 and vld_o is 0. Until the first frame boundary the active format is luma/chroma without codes (fmt code 1) with byte order mode code 0.
- R2: In fmt codes 0 and 1, the group is four bytes and mode_i selects the order. Code 0 gives y0, cb, y1, cr. Code 1 gives y0, cr, y1, cb. Code 2 gives cb, y0, cr, y1. Code 3 gives cr, y0, cb, y1.
- R3: In fmt code 2 the group is two bytes and mode_i[0] selects the packing. With 0 the bytes are {r[4:0], g[5:3]} then {g[2:0], b[4:0]}. With 1 the bytes are {b[4:0], g[5:3]} then {g[2:0], r[4:0]}. mode_i[1] is ignored.
- R4: In fmt code 3 each sample takes two bytes: {6'b0, raw[9:8]} first, then raw[7:0]. mode_i is ignored.
- R5: The byte position within a group restarts at the first cycle of every line, even if the previous line ended part way through a group.
- R6: The byte chosen from the inputs sampled at clock edge n is on data_o after edge n+4, and vld_o is high with it.
- R7: In fmt code 0, the four outputs just before the first pixel byte of a line are 0xFF, 0x00, 0x00 and a status byte. The status byte is {1, F, V, H=0, V^H, F^H, F^V, F^V^H}, with F and V taken from field_i and vblank_i in the line's first cycle.
- R8: In fmt code 0, the four outputs just after the last pixel byte of a line are 0xFF, 0x00, 0x00 and a status byte with H=1, using the same F and V that were captured for that line.
- R9: On idle cycles data_o is 0x00 in fmt codes 1 to 3. In fmt code 0 it alternates 0x80, 0x10, starting with 0x80 after any non-idle byte and after reset.
- R10: fmt_i and mode_i take effect only at a clock edge where frame_start_i is high. That includes a line whose first cycle is the same edge. At all other edges they have no effect.
- R11: vld_o is high only on pixel bytes, never on codes or blanking.

Lines must be separated by at least eight idle cycles. frame_start_i is raised either in such a gap or on the first cycle of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame boundary pulse; loads format and mode |
| line_valid_i | input | 1 | High while the line's pixel bytes are being presented |
| fmt_i | input | 2 | Format: 0 luma/chroma with codes, 1 without codes, 2 5-6-5, 3 raw |
| mode_i | input | 2 | Byte order within the format |
| field_i | input | 1 | Field bit for the status byte |
| vblank_i | input | 1 | Vertical blanking bit for the status byte |
| y0_i | input | 8 | First luma of the pixel pair |
| y1_i | input | 8 | Second luma of the pixel pair |
| cb_i | input | 8 | Blue-difference chroma |
| cr_i | input | 8 | Red-difference chroma |
| r_i | input | 5 | Red component |
| g_i | input | 6 | Green component |
| b_i | input | 5 | Blue component |
| raw_i | input | 10 | Raw sensor sample |
| data_o | output | 8 | Output byte |
| vld_o | output | 1 | High on pixel bytes |

## Verification
The frame boundary and the start of a line can land on the same clock edge. In that case the new format has to govern both the start code and the first pixel byte, while the register that holds the format is being loaded in that same cycle. The bench provokes this by raising frame_start_i on a line's first cycle while switching into the embedded-code format. It also switches fmt_i and mode_i mid-frame with no boundary present. A behavioural model checks every cycle's output: which format governs each byte, whether the start code appears, and whether the blanking parity is right.

// File: rtl/pixbyte_fmt_pkg.sv
package pixbyte_fmt_pkg;

  typedef enum logic [1:0] {
    FMT_CODED = 2'd0,
    FMT_PLAIN = 2'd1,
    FMT_RGB   = 2'd2,
    FMT_RAW   = 2'd3
  } fmt_e;

  // number of bytes in a timing code, also the data path latency
  localparam int CODE_LEN = 4;
  localparam int R_W      = 5;
  localparam int G_W      = 6;
  localparam int B_W      = 5;

  // status byte of a timing code: fixed 1, F, V, H, then protection bits
  function automatic logic [7:0] status_byte(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/pixbyte_phase.sv
module pixbyte_phase
  import pixbyte_fmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       lv_i,
  input  logic       quad_i,
  output logic       start_o,
  output logic       stop_o,
  output logic [1:0] phase_o
);

  logic       lv_q;
  logic [1:0] cnt_q;
  logic [1:0] last;

  assign start_o = lv_i & ~lv_q;
  assign stop_o  = ~lv_i & lv_q;
  assign phase_o = lv_q ? cnt_q : 2'd0;
  assign last    = quad_i ? 2'd3 : 2'd1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lv_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      lv_q <= lv_i;
      if (lv_i) cnt_q <= (phase_o == last) ? 2'd0 : phase_o + 2'd1;
    end
  end

endmodule

// File: rtl/pixbyte_sel.sv
module pixbyte_sel
  import pixbyte_fmt_pkg::*;
#(
  parameter int RAW_W = 10
) (
  input  fmt_e             fmt_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       phase_i,
  input  logic [7:0]       y0_i,
  input  logic [7:0]       y1_i,
  input  logic [7:0]       cb_i,
  input  logic [7:0]       cr_i,
  input  logic [R_W-1:0]   r_i,
  input  logic [G_W-1:0]   g_i,
  input  logic [B_W-1:0]   b_i,
  input  logic [RAW_W-1:0] raw_i,
  output logic [7:0]       byte_o
);

  localparam int PAD_W = 16 - RAW_W;

  logic [7:0]  yc_byte;
  logic [15:0] rgb_word;
  logic [15:0] raw_word;

  always_comb begin
    unique case ({mode_i, phase_i})
      4'b00_00: yc_byte = y0_i;
      4'b00_01: yc_byte = cb_i;
      4'b00_10: yc_byte = y1_i;
      4'b00_11: yc_byte = cr_i;
      4'b01_00: yc_byte = y0_i;
      4'b01_01: yc_byte = cr_i;
      4'b01_10: yc_byte = y1_i;
      4'b01_11: yc_byte = cb_i;
      4'b10_00: yc_byte = cb_i;
      4'b10_01: yc_byte = y0_i;
      4'b10_10: yc_byte = cr_i;
      4'b10_11: yc_byte = y1_i;
      4'b11_00: yc_byte = cr_i;
      4'b11_01: yc_byte = y0_i;
      4'b11_10: yc_byte = cb_i;
      default:  yc_byte = y1_i;
    endcase
  end

  assign rgb_word = mode_i[0] ? {b_i, g_i, r_i} : {r_i, g_i, b_i};
  assign raw_word = {{PAD_W{1'b0}}, raw_i};

  always_comb begin
    unique case (fmt_i)
      FMT_RGB: byte_o = phase_i[0] ? rgb_word[7:0] : rgb_word[15:8];
      FMT_RAW: byte_o = phase_i[0] ? raw_word[7:0] : raw_word[15:8];
      default: byte_o = yc_byte;
    endcase
  end

endmodule

// File: rtl/pixbyte_frame.sv
module pixbyte_frame
  import pixbyte_fmt_pkg::*;
#(
  parameter logic [7:0] BLANK_LO = 8'h10,
  parameter logic [7:0] BLANK_HI = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  fmt_e       fmt_i,
  input  logic       lv_i,
  input  logic       start_i,
  input  logic       field_i,
  input  logic       vblank_i,
  input  logic [7:0] byte_i,
  output logic [7:0] data_o,
  output logic       vld_o
);

  localparam int PIPE = CODE_LEN;

  logic [7:0] dp_q [PIPE];
  logic       vp_q [PIPE];
  logic [1:0] sav_q, eav_q, sav_n, eav_n;
  logic       f_q, v_q, blk_q, idle;
  logic [7:0] nxt_d;
  logic       nxt_v;
  logic       coded;

  assign coded = (fmt_i == FMT_CODED);

  always_comb begin
    nxt_d = 8'h00;
    nxt_v = 1'b0;
    sav_n = sav_q;
    eav_n = eav_q;
    idle  = 1'b0;
    if (vp_q[PIPE-1]) begin
      nxt_d = dp_q[PIPE-1];
      nxt_v = 1'b1;
    end else if (coded && start_i) begin
      nxt_d = 8'hFF;
      sav_n = 2'd1;
    end else if (sav_q != 2'd0) begin
      nxt_d = (sav_q == 2'd3) ? status_byte(f_q, v_q, 1'b0) : 8'h00;
      sav_n = sav_q + 2'd1;
    end else if (coded && vld_o) begin
      nxt_d = 8'hFF;
      eav_n = 2'd1;
    end else if (eav_q != 2'd0) begin
      nxt_d = (eav_q == 2'd3) ? status_byte(f_q, v_q, 1'b1) : 8'h00;
      eav_n = eav_q + 2'd1;
    end else begin
      idle  = 1'b1;
      nxt_d = coded ? (blk_q ? BLANK_LO : BLANK_HI) : 8'h00;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < PIPE; k++) begin
        dp_q[k] <= 8'h00;
        vp_q[k] <= 1'b0;
      end
      sav_q  <= 2'd0;
      eav_q  <= 2'd0;
      f_q    <= 1'b0;
      v_q    <= 1'b0;
      blk_q  <= 1'b0;
      data_o <= 8'h00;
      vld_o  <= 1'b0;
    end else begin
      dp_q[0] <= byte_i;
      vp_q[0] <= lv_i;
      for (int k = 1; k < PIPE; k++) begin
        dp_q[k] <= dp_q[k-1];
        vp_q[k] <= vp_q[k-1];
      end
      if (start_i) begin
        f_q <= field_i;
        v_q <= vblank_i;
      end
      sav_q  <= sav_n;
      eav_q  <= eav_n;
      blk_q  <= (idle && coded) ? ~blk_q : 1'b0;
      data_o <= nxt_d;
      vld_o  <= nxt_v;
    end
  end

endmodule

// File: rtl/pixbyte_fmt.sv
module pixbyte_fmt
  import pixbyte_fmt_pkg::*;
#(
  parameter int         RAW_W    = 10,
  parameter logic [7:0] BLANK_LO = 8'h10,
  parameter logic [7:0] BLANK_HI = 8'h80
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             frame_start_i,
  input  logic             line_valid_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       mode_i,
  input  logic             field_i,
  input  logic             vblank_i,
  input  logic [7:0]       y0_i,
  input  logic [7:0]       y1_i,
  input  logic [7:0]       cb_i,
  input  logic [7:0]       cr_i,
  input  logic [4:0]       r_i,
  input  logic [5:0]       g_i,
  input  logic [4:0]       b_i,
  input  logic [RAW_W-1:0] raw_i,
  output logic [7:0]       data_o,
  output logic             vld_o
);

  fmt_e       fmt_act, fmt_eff;
  logic [1:0] mode_act, mode_eff;
  logic       start, stop, quad;
  logic [1:0] phase;
  logic [7:0] sel_byte;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fmt_act  <= FMT_PLAIN;
      mode_act <= 2'd0;
    end else if (frame_start_i) begin
      fmt_act  <= fmt_e'(fmt_i);
      mode_act <= mode_i;
    end
  end

  assign fmt_eff  = frame_start_i ? fmt_e'(fmt_i) : fmt_act;
  assign mode_eff = frame_start_i ? mode_i : mode_act;
  assign quad     = (fmt_eff == FMT_CODED) || (fmt_eff == FMT_PLAIN);

  pixbyte_phase u_phase (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .lv_i    (line_valid_i),
    .quad_i  (quad),
    .start_o (start),
    .stop_o  (stop),
    .phase_o (phase)
  );

  pixbyte_sel #(.RAW_W(RAW_W)) u_sel (
    .fmt_i   (fmt_eff),
    .mode_i  (mode_eff),
    .phase_i (phase),
    .y0_i    (y0_i),
    .y1_i    (y1_i),
    .cb_i    (cb_i),
    .cr_i    (cr_i),
    .r_i     (r_i),
    .g_i     (g_i),
    .b_i     (b_i),
    .raw_i   (raw_i),
    .byte_o  (sel_byte)
  );

  pixbyte_frame #(.BLANK_LO(BLANK_LO), .BLANK_HI(BLANK_HI)) u_frame (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .fmt_i    (fmt_eff),
    .lv_i     (line_valid_i),
    .start_i  (start),
    .field_i  (field_i),
    .vblank_i (vblank_i),
    .byte_i   (sel_byte),
    .data_o   (data_o),
    .vld_o    (vld_o)
  );

endmodule

// File: rtl/pixbyte_fmt_chk.sv
module pixbyte_fmt_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       frame_start_i,
  input logic       line_valid_i,
  input logic [1:0] fmt_act,
  input logic [1:0] mode_act,
  input logic [7:0] data_o,
  input logic       vld_o
);

  logic [2:0] since_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) since_q <= 3'd0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  // R1
  reset_out_chk: assert property (@(posedge clk_i) rst_i |=> (data_o == 8'h00 && !vld_o));

  // R6
  latency_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (since_q >= 3'd6) |-> (vld_o == $past(line_valid_i, 5)));

  // R7
  sav_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((since_q >= 3'd6) && $rose(vld_o) && fmt_act == 2'd0) |->
      ($past(data_o, 4) == 8'hFF && $past(data_o, 3) == 8'h00 &&
       $past(data_o, 2) == 8'h00 && $past(data_o, 1) >= 8'h80 && !$past(data_o[4], 1)));

  // R8
  eav_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(vld_o) && fmt_act == 2'd0) |-> (data_o == 8'hFF));

  // R9
  quiet_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fmt_act != 2'd0 && !vld_o) |-> (data_o == 8'h00));

  // R10
  fmt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !frame_start_i |=> ($stable(fmt_act) && $stable(mode_act)));

endmodule

bind pixbyte_fmt pixbyte_fmt_chk u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .frame_start_i (frame_start_i),
  .line_valid_i  (line_valid_i),
  .fmt_act       (fmt_act),
  .mode_act      (mode_act),
  .data_o        (data_o),
  .vld_o         (vld_o)
);

// File: tb/pixbyte_fmt_bench.sv
module pixbyte_fmt_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fs = 1'b0, lv = 1'b0, fld = 1'b0, vbl = 1'b0;
  logic [1:0] fmt = 2'd0, mode = 2'd0;
  logic [7:0] y0 = 8'h0, y1 = 8'h0, cb = 8'h0, cr = 8'h0;
  logic [4:0] r = 5'h0, b = 5'h0;
  logic [5:0] g = 6'h0;
  logic [9:0] raw = 10'h0;
  logic [7:0] data;
  logic       vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixbyte_fmt u_pixbyte_fmt (
    .clk_i(clk), .rst_i(rst), .frame_start_i(fs), .line_valid_i(lv),
    .fmt_i(fmt), .mode_i(mode), .field_i(fld), .vblank_i(vbl),
    .y0_i(y0), .y1_i(y1), .cb_i(cb), .cr_i(cr), .r_i(r), .g_i(g), .b_i(b),
    .raw_i(raw), .data_o(data), .vld_o(vld)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] exp_b [int];
  bit         exp_v [int];
  string      exp_t [int];
  logic [1:0] fmt_at [int];
  string      cur_tag = "R1";

  // reference model state
  logic [1:0] m_fmt = 2'd1, m_mode = 2'd0;
  bit         m_lvp = 0, m_f = 0, m_v = 0, m_bp = 0;
  int         m_pos = 0;

  function automatic logic [7:0] ref_status(bit f, bit v, bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] ref_byte(logic [1:0] f, logic [1:0] md, int pos);
    logic [7:0] seq [4];
    logic [15:0] w;
    if (f <= 2'd1) begin
      case (md)
        2'd0: seq = '{y0, cb, y1, cr};
        2'd1: seq = '{y0, cr, y1, cb};
        2'd2: seq = '{cb, y0, cr, y1};
        default: seq = '{cr, y0, cb, y1};
      endcase
      return seq[pos];
    end
    if (f == 2'd2) w = md[0] ? {b, g, r} : {r, g, b};
    else w = {6'b000000, raw};
    return (pos == 0) ? w[15:8] : w[7:0];
  endfunction

  task automatic check(input string tag, input logic [7:0] a_d, input logic [7:0] e_d,
                       input bit a_v, input bit e_v);
    checks++;
    if (a_d !== e_d || a_v !== e_v) begin
      fails++;
      $display("FAIL %s cycle %0d: data=%02h vld=%0b expected data=%02h vld=%0b",
               tag, cyc, a_d, a_v, e_d, e_v);
    end
  endtask

  task automatic schedule(int c, logic [7:0] v, bit valid, string tag);
    exp_b[c] = v;
    exp_v[c] = valid;
    exp_t[c] = tag;
  endtask

  // drive one cycle: inputs are already set; model, clock, then compare
  task automatic tick();
    logic [1:0] ef, em;
    int glen;
    bit start, stop;
    logic [7:0] eb;
    bit ev;
    string tg;
    ef = fs ? fmt : m_fmt;
    em = fs ? mode : m_mode;
    start = lv && !m_lvp;
    stop  = !lv && m_lvp;
    glen  = (ef <= 2'd1) ? 4 : 2;
    if (start) begin
      m_pos = 0;
      m_f = fld;
      m_v = vbl;
      if (ef == 2'd0) begin
        schedule(cyc,     8'hFF, 0, "R7");
        schedule(cyc + 1, 8'h00, 0, "R7");
        schedule(cyc + 2, 8'h00, 0, "R7");
        schedule(cyc + 3, ref_status(fld, vbl, 0), 0, "R7");
      end
    end
    if (stop && ef == 2'd0) begin
      schedule(cyc + 4, 8'hFF, 0, "R8");
      schedule(cyc + 5, 8'h00, 0, "R8");
      schedule(cyc + 6, 8'h00, 0, "R8");
      schedule(cyc + 7, ref_status(m_f, m_v, 1), 0, "R8");
    end
    if (lv) begin
      schedule(cyc + 4, ref_byte(ef, em, m_pos), 1, cur_tag);
      m_pos = (m_pos + 1) % glen;
    end
    fmt_at[cyc] = ef;
    if (fs) begin
      m_fmt = fmt;
      m_mode = mode;
    end
    m_lvp = lv;
    @(posedge clk);
    @(negedge clk);
    if (exp_b.exists(cyc)) begin
      eb = exp_b[cyc]; ev = exp_v[cyc]; tg = exp_t[cyc];
      m_bp = 0;
      exp_b.delete(cyc); exp_v.delete(cyc); exp_t.delete(cyc);
    end else begin
      ev = 0; tg = "R9";
      if (fmt_at[cyc] == 2'd0) begin
        eb = m_bp ? 8'h10 : 8'h80;
        m_bp = !m_bp;
      end else begin
        eb = 8'h00;
        m_bp = 0;
      end
    end
    if (ev) tg = {tg, " R6 R11"};
    check(tg, data, eb, vld, ev);
    fmt_at.delete(cyc);
    cyc++;
  endtask

  task automatic randomize_pix();
    {y0, y1, cb, cr} = $urandom;
    {r, g, b} = 16'($urandom);
    raw = 10'($urandom);
  endtask

  task automatic idle(int n);
    lv = 0; fs = 0;
    for (int i = 0; i < n; i++) begin
      randomize_pix();
      tick();
    end
  endtask

  task automatic line(int len, bit f, bit v);
    fld = f; vbl = v; lv = 1;
    for (int i = 0; i < len; i++) begin
      randomize_pix();
      tick();
      fs = 0;
    end
    lv = 0;
    idle(GAP);
  endtask

  task automatic frame(logic [1:0] f, logic [1:0] md, int nl, int len, string tag);
    cur_tag = tag;
    fmt = f; mode = md; fs = 1;
    randomize_pix();
    tick();
    fs = 0;
    idle(2);
    for (int k = 0; k < nl; k++) line(len + k, k[0], k[1]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at reset values
    check("R1", data, 8'h00, vld, 1'b0);
    rst = 0;
    idle(3);
    // R1: default ordering before any frame boundary
    cur_tag = "R1";
    line(8, 0, 0);
    for (int md = 0; md < 4; md++) frame(2'd1, 2'(md), 2, 8, "R2");
    frame(2'd2, 2'd0, 2, 6, "R3");
    frame(2'd2, 2'd3, 2, 6, "R3");
    frame(2'd3, 2'd2, 2, 6, "R4");
    // R5: lines ending part way through a group
    frame(2'd1, 2'd2, 3, 5, "R5");
    frame(2'd2, 2'd1, 3, 3, "R5");
    // R7 R8 R9: coded format with all field and blanking flag values
    for (int md = 0; md < 4; md++) frame(2'd0, 2'(md), 4, 7, "R2");
    // R10: mid-frame register change is ignored
    frame(2'd3, 2'd0, 1, 4, "R10");
    fmt = 2'd2; mode = 2'd1;
    line(6, 0, 0);
    fmt = 2'd0; mode = 2'd3;
    line(5, 1, 0);
    // R10: frame boundary on the first cycle of a line
    cur_tag = "R10";
    fmt = 2'd0; mode = 2'd2; fs = 1;
    line(8, 1, 1);
    fmt = 2'd1; mode = 2'd1; fs = 1;
    line(6, 0, 0);
    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule